// File: doc/BRIEF.md
# Iterative GCD Engine with Handshakes

This block computes the greatest common divisor of two unsigned operands of parameterizable width. A producer offers an operand pair on a valid/ready input port. The engine takes the pair into two working registers. It then reduces them with a swap-or-subtract step once per clock. When the second register reaches zero, the first register holds the answer. The answer stays on a valid/ready output port until the consumer takes it.

A datapath and a control unit build the engine. The datapath has two operand registers. Each has an input multiplexer and an enable of its own. It also has a magnitude comparator, a zero detector and a subtractor. The control unit is a three-state machine:

- ST_WAIT: idle and ready for operands.
- ST_CALC: reducing the operands.
- ST_DONE: presenting the answer.

Transitions:

- ST_WAIT to ST_CALC: on an input transfer.
- ST_CALC to ST_DONE: when the second register is zero.
- ST_DONE to ST_WAIT: on an output transfer.
- Reset (synchronous, active high) forces ST_WAIT from any state.

Top module: `gcd_engine`

## Requirements
- R1: In the first cycle after reset is released, `op_ready` is 1 and `res_valid` is 0.
- R2: `op_ready` and `res_valid` are never high in the same cycle.
- R3: For any operand pair, the value presented with `res_valid` equals the greatest common divisor of the two operands.
- R4: A zero operand is handled without hanging. gcd(x,0)=x, gcd(0,x)=x and gcd(0,0)=0.
- R5: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_value` does not change.
- R6: Operand pairs offered with `op_valid` while `op_ready` is low are ignored. The answer of the problem in flight is unaffected.
- R7: The cycle after an output transfer (`res_valid` and `res_ready` both high at a clock edge), `res_valid` is 0 and `op_ready` is 1.
- R8: The cycle after an input transfer (`op_valid` and `op_ready` both high at a clock edge), `op_ready` is 0.
- R9: If the accepted second operand is zero, `res_valid` rises exactly two clock edges after the accepting edge, carrying the first operand.
- R10: Each reduction cycle does one of two things. If A < B, it swaps A and B. Otherwise it replaces A with A − B. So (a,a) finishes with `res_valid` four edges after the accepting edge, carrying a, for any nonzero a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Producer offers an operand pair |
| op_ready | output | 1 | Engine can take an operand pair (ST_WAIT only) |
| op_a | input | W | First operand, unsigned |
| op_b | input | W | Second operand, unsigned |
| res_valid | output | 1 | Answer is present (ST_DONE only) |
| res_ready | input | 1 | Consumer takes the answer |
| res_value | output | W | Greatest common divisor |

## Verification
The bench covers zero operands in either position and both together. A design without a zero exit would loop forever on those cases, or return the wrong operand. Equal operands and large quotient ratios (n,1) check that the swap and the subtract are chosen correctly on each cycle. A wrong comparison there gives a wrong answer or never converges.

Random stalls on `res_ready` catch an answer that drifts or drops early under back-pressure. Operand pairs are offered while the engine is busy, which catches a design that reloads its registers outside ST_WAIT. Exact cycle counts on the zero-operand and equal-operand cases expose any extra or missing step in the state machine.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_CALC = 2'd1,
        ST_DONE = 2'd2
    } gcd_state_e;

    typedef enum logic [1:0] {
        ASEL_LOAD = 2'd0,
        ASEL_FROM_B = 2'd1,
        ASEL_DIFF = 2'd2
    } a_sel_e;

    typedef enum logic {
        BSEL_LOAD = 1'b0,
        BSEL_FROM_A = 1'b1
    } b_sel_e;

    typedef struct packed {
        a_sel_e a_sel;
        logic a_en;
        b_sel_e b_sel;
        logic b_en;
    } gcd_ctrl_t;

endpackage

// File: rtl/gcd_en_reg.sv
module gcd_en_reg #(
    parameter int W = 16
) (
    input logic clk,
    input logic en,
    input logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (en) begin
            q_r <= d;
        end
    end

    assign q = q_r;

endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
    import gcd_pkg::*;
#(
    parameter int W = 16
) (
    input logic clk,
    input logic [W-1:0] in_a,
    input logic [W-1:0] in_b,
    input gcd_ctrl_t ctrl,
    output logic a_lt_b,
    output logic b_zero,
    output logic [W-1:0] value_a
);

    logic [W-1:0] reg_a;
    logic [W-1:0] reg_b;
    logic [W-1:0] next_a;
    logic [W-1:0] next_b;
    logic [W-1:0] diff;

    // Selector for register A: operand, swap partner, or difference.
    always_comb begin
        unique case (ctrl.a_sel)
            ASEL_FROM_B: next_a = reg_b;
            ASEL_DIFF: next_a = diff;
            default: next_a = in_a;
        endcase
    end

    // Selector for register B: operand or swap partner.
    always_comb begin
        unique case (ctrl.b_sel)
            BSEL_FROM_A: next_b = reg_a;
            default: next_b = in_b;
        endcase
    end

    gcd_en_reg #(.W(W)) u_reg_a (
        .clk(clk),
        .en(ctrl.a_en),
        .d(next_a),
        .q(reg_a)
    );

    gcd_en_reg #(.W(W)) u_reg_b (
        .clk(clk),
        .en(ctrl.b_en),
        .d(next_b),
        .q(reg_b)
    );

    assign diff = reg_a - reg_b;
    assign a_lt_b = (reg_a < reg_b);
    assign b_zero = (reg_b == '0);
    assign value_a = reg_a;

endmodule

// File: rtl/gcd_control.sv
module gcd_control
    import gcd_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic op_valid,
    input logic res_ready,
    input logic a_lt_b,
    input logic b_zero,
    output logic op_ready,
    output logic res_valid,
    output gcd_ctrl_t ctrl,
    output gcd_state_e state
);

    gcd_state_e state_q;
    gcd_state_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs and next state. Defaults are inactive and each state overrides what it needs.
    always_comb begin
        state_d = state_q;
        op_ready = 1'b0;
        res_valid = 1'b0;
        ctrl.a_sel = ASEL_LOAD;
        ctrl.a_en = 1'b0;
        ctrl.b_sel = BSEL_LOAD;
        ctrl.b_en = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                op_ready = 1'b1;
                ctrl.a_sel = ASEL_LOAD;
                ctrl.b_sel = BSEL_LOAD;
                if (op_valid) begin
                    ctrl.a_en = 1'b1;
                    ctrl.b_en = 1'b1;
                    state_d = ST_CALC;
                end
            end
            ST_CALC: begin
                if (a_lt_b) begin
                    ctrl.a_sel = ASEL_FROM_B;
                    ctrl.a_en = 1'b1;
                    ctrl.b_sel = BSEL_FROM_A;
                    ctrl.b_en = 1'b1;
                end else if (!b_zero) begin
                    ctrl.a_sel = ASEL_DIFF;
                    ctrl.a_en = 1'b1;
                end else begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                res_valid = 1'b1;
                if (res_ready) begin
                    state_d = ST_WAIT;
                end
            end
            default: begin
                state_d = ST_WAIT;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/gcd_engine.sv
module gcd_engine
    import gcd_pkg::*;
#(
    parameter int W = 16
) (
    input logic clk,
    input logic rst,
    input logic op_valid,
    output logic op_ready,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    output logic res_valid,
    input logic res_ready,
    output logic [W-1:0] res_value
);

    gcd_ctrl_t ctrl;
    gcd_state_e fsm_state;
    logic a_lt_b;
    logic b_zero;

    gcd_control u_ctrl (
        .clk(clk),
        .rst(rst),
        .op_valid(op_valid),
        .res_ready(res_ready),
        .a_lt_b(a_lt_b),
        .b_zero(b_zero),
        .op_ready(op_ready),
        .res_valid(res_valid),
        .ctrl(ctrl),
        .state(fsm_state)
    );

    gcd_datapath #(.W(W)) u_dp (
        .clk(clk),
        .in_a(op_a),
        .in_b(op_b),
        .ctrl(ctrl),
        .a_lt_b(a_lt_b),
        .b_zero(b_zero),
        .value_a(res_value)
    );

endmodule

// File: rtl/gcd_engine_sva.sv
module gcd_engine_sva #(
    parameter int W = 16
) (
    input logic clk,
    input logic rst,
    input logic op_valid,
    input logic op_ready,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic res_valid,
    input logic res_ready,
    input logic [W-1:0] res_value
);

    AST_RESET_EXIT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (op_ready && !res_valid)); // R1

    AST_HS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(op_ready && res_valid)); // R2

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_value))); // R5

    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_ready) |=> (!res_valid && op_ready)); // R7

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready) |=> !op_ready); // R8

    AST_ZERO_B_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready && op_b == '0) |=> ##1 (res_valid && res_value == $past(op_a, 2))); // R9

endmodule

bind gcd_engine gcd_engine_sva #(.W(W)) u_sva (
    .clk(clk),
    .rst(rst),
    .op_valid(op_valid),
    .op_ready(op_ready),
    .op_a(op_a),
    .op_b(op_b),
    .res_valid(res_valid),
    .res_ready(res_ready),
    .res_value(res_value)
);

// File: tb/tb_gcd_engine.sv
module tb_gcd_engine;

    localparam int W = 16;
    localparam int STEP_LIMIT = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic res_ready = 1'b0;
    logic op_ready;
    logic res_valid;
    logic [W-1:0] res_value;

    int n_checks = 0;
    int n_fails = 0;
    bit aborted = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gcd_engine #(.W(W)) dut (
        .clk(clk),
        .rst(rst),
        .op_valid(op_valid),
        .op_ready(op_ready),
        .op_a(op_a),
        .op_b(op_b),
        .res_valid(res_valid),
        .res_ready(res_ready),
        .res_value(res_value)
    );

    function automatic logic [W-1:0] ref_gcd(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [W-1:0] p = x;
        logic [W-1:0] q = y;
        logic [W-1:0] t;
        while (q != 0) begin
            t = p % q;
            p = q;
            q = t;
        end
        return p;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One full problem. Inputs are driven and outputs sampled on falling edges.
    task automatic run_problem(input logic [W-1:0] a, input logic [W-1:0] b,
                               input int stall_pct, input bit noise, input int exp_lat);
        int lat;
        int stalls;
        logic [W-1:0] held;
        if (aborted) return;
        while (!op_ready) @(negedge clk);
        op_valid = 1'b1;
        op_a = a;
        op_b = b;
        @(negedge clk);
        check(op_ready == 1'b0, "R8 op_ready after accept", op_ready, 0);
        op_valid = 1'b0;
        lat = 1;
        while (!res_valid) begin
            if (noise) begin
                // R6: pairs offered while busy must be ignored.
                op_valid = 1'b1;
                op_a = W'($urandom);
                op_b = W'($urandom);
            end
            @(negedge clk);
            lat++;
            if (lat > STEP_LIMIT) begin
                check(1'b0, "R3 watchdog no result", lat, STEP_LIMIT);
                aborted = 1'b1;
                op_valid = 1'b0;
                return;
            end
        end
        op_valid = 1'b0;
        if (exp_lat > 0) begin
            check(lat == exp_lat, "R9/R10 result latency", lat, exp_lat);
        end
        check(op_ready == 1'b0, "R2 ready with valid", op_ready, 0);
        check(res_value == ref_gcd(a, b), (a == 0 || b == 0) ? "R4 zero operand" :
              (noise ? "R6 busy noise" : "R3 gcd value"), res_value, ref_gcd(a, b));
        held = res_value;
        stalls = 0;
        while (($urandom % 100) < stall_pct && stalls < 6) begin
            @(negedge clk);
            stalls++;
            check(res_valid && res_value == held, "R5 held under stall", res_value, held);
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        check(!res_valid && op_ready, "R7 release", {res_valid, op_ready}, 2'b01);
    endtask

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(op_ready == 1'b1 && res_valid == 1'b0, "R1 reset state", {op_ready, res_valid}, 2'b10);

        // Directed corner cases.
        run_problem(16'd27, 16'd15, 0, 1'b0, 0);
        run_problem(16'd42, 16'd0, 50, 1'b0, 2);
        run_problem(16'd0, 16'd0, 0, 1'b0, 2);
        run_problem(16'd0, 16'd37, 0, 1'b0, 0);
        run_problem(16'd9, 16'd9, 30, 1'b0, 4);
        run_problem(16'd65535, 16'd65535, 0, 1'b0, 4);
        run_problem(16'd1000, 16'd1, 40, 1'b0, 0);
        run_problem(16'd1, 16'd4000, 0, 1'b0, 0);
        run_problem(16'd48, 16'd180, 60, 1'b1, 0);
        run_problem(16'd65535, 16'd0, 0, 1'b1, 2);

        // Constrained random: mostly small operands to bound run time, some with zeros.
        for (int i = 0; i < 250; i++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = W'($urandom % 256);
            rb = W'($urandom % 256);
            if (($urandom % 16) == 0) rb = '0;
            if (($urandom % 4) == 0) begin
                ra = ra * W'(($urandom % 8) + 1);
                rb = rb * W'(($urandom % 8) + 1);
            end
            run_problem(ra, rb, 50, (i % 3) == 0, 0);
        end

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule